// File: doc/BRIEF.md
# Card Host Status Interrupt Controller

This block holds the event status word and the interrupt-enable word of a memory-card host controller. The command engine, the data engine, the two-half transfer buffer and the card-detect logic raise single-cycle pulses on a 32-bit event vector. Each pulse sets its own bit in the status word, and the bit stays set until software clears it. Some status positions only mirror live level inputs: the buffer empty/full flags, the card clock running flag and the buffer read/write ready flags. When a write CRC error is raised, the two-bit CRC response code the card returned is captured next to it.

Software reaches both words through one register port. A select bit picks the word, and the read data follows the select with no delay. A write to the status word clears every bit written as one. A write to the enable word loads its implemented bits. The enable bits gate status bits through a fixed cross-mapping, so each enable sits at a different position from the status bit it gates. The result drives a registered interrupt line and a separate registered wake-up line. A six-bit error view and its OR are also driven out.

Top module: `card_evt_irq_ctrl`

## Requirements
- R1: A pulse on `evt_set[i]` sets status bit i for each sticky position i, and the bit holds until cleared. The sticky positions are 31 (card inserted), 30 (card removed), 25 (buffer underrun), 24 (buffer overflow), 14 (SDIO interrupt), 13 (command response ended), 12 (write done), 11 (read/data done), 5 (response CRC error), 3 (read CRC error), 2 (write CRC error), 1 (response timeout) and 0 (read timeout).
- R2: A write with `reg_sel`=0 clears each sticky bit whose `reg_wdata` bit is 1. A 0 in `reg_wdata` leaves the bit unchanged.
- R3: If a pulse and a clearing write reach the same sticky bit in the same cycle, the bit ends the cycle set.
- R4: The level positions read the live inputs directly: 29..26 are `buf_flags[3:0]`, 8 is `bus_clk_on`, 7 is `rd_ready` and 6 is `wr_ready`. Writes do not affect them, and pulses at non-sticky positions are ignored. Positions 23..15, 10..9 and 4 read 0 except where R5 applies.
- R5: A pulse on `evt_set[2]` loads `wcrc_code` into status bits 10..9, where code 2 means the card returned no CRC response. Writes to bits 10..9 are ignored. A write that clears bit 2 with no pulse on `evt_set[2]` in the same cycle returns the code to 0.
- R6: A write with `reg_sel`=1 loads enable bits 0..4 and 12..18 from `reg_wdata`. All other enable bits read 0. A read with `reg_sel`=1 returns the enable word, and a read with `reg_sel`=0 returns the status word.
- R7: `irq` is the registered OR of the following enable-to-status pairs: enable 0 with status 11, 1 with 12, 2 with 13, 3 with 6, 4 with 7, 13 with 14, 14 with 30 and 15 with 31. Enable 12 pairs with the `dat0_level` input. The line changes one clock after the status it reflects.
- R8: `wake` is the registered OR of three pairs: enable 16 with status 30, 17 with 31 and 18 with 14. It is also one clock late.
- R9: `err_flags` equals status bits 5..0 ANDed with mask 0x2F, and `err_any` is the OR of `err_flags`.
- R10: Asserting `rst_n` low clears all sticky bits, the CRC code, all enables, `irq` and `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 32 | Write data (ones clear for status) |
| reg_rdata | output | 32 | Read data of the selected word |
| evt_set | input | 32 | Single-cycle event pulses at status positions |
| wcrc_code | input | 2 | Card CRC response code captured on write CRC error |
| buf_flags | input | 4 | Buffer empty/full levels |
| bus_clk_on | input | 1 | Card clock running level |
| rd_ready | input | 1 | Buffer read ready level |
| wr_ready | input | 1 | Buffer write ready level |
| dat0_level | input | 1 | Data line 0 level for its interrupt source |
| irq | output | 1 | Registered interrupt request |
| wake | output | 1 | Registered wake-up request |
| err_flags | output | 6 | Masked error bits of the status word |
| err_any | output | 1 | Any error bit set |

## Verification
The bench builds the block with its default 32-bit word. At that width every sticky, level, code and enable position defined by the maps exists, so each cross-mapping pair and each ignored position can be driven. Random sparse pulses, clears, enable loads and level changes put pulse and clear on the same bit in the same cycle many times. They also give level inputs that change while an enable gates them, and CRC codes overwritten before they are cleared.

// File: rtl/card_evt_irq_pkg.sv
package card_evt_irq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned ERR_W  = 6;

  // positions that latch pulses
  localparam logic [WORD_W-1:0] STICKY_MASK = 32'hC300_782F;
  // positions mirrored from live inputs
  localparam logic [WORD_W-1:0] LEVEL_MASK  = 32'h3C00_01C0;
  // implemented enable positions
  localparam logic [WORD_W-1:0] EN_MASK     = 32'h0007_F01F;
  localparam logic [ERR_W-1:0]  ERR_MASK    = 6'h2F;

  localparam int unsigned CODE_LSB  = 9;
  localparam int unsigned WCRC_BIT  = 2;
  localparam int unsigned BUF_LSB   = 26;
  localparam int unsigned CLKON_BIT = 8;
  localparam int unsigned RDRDY_BIT = 7;
  localparam int unsigned WRRDY_BIT = 6;
  localparam int unsigned DAT0_EN   = 12;

  // enable -> status cross-map for the interrupt line
  localparam int unsigned NIRQ = 8;
  localparam int unsigned IRQ_EN_IDX [NIRQ] = '{0, 1, 2, 3, 4, 13, 14, 15};
  localparam int unsigned IRQ_ST_IDX [NIRQ] = '{11, 12, 13, 6, 7, 14, 30, 31};

  // enable -> status cross-map for the wake-up line
  localparam int unsigned NWAKE = 3;
  localparam int unsigned WAKE_EN_IDX [NWAKE] = '{16, 17, 18};
  localparam int unsigned WAKE_ST_IDX [NWAKE] = '{30, 31, 14};
endpackage

// File: rtl/cei_status_bank.sv
module cei_status_bank
  import card_evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [DATA_W-1:0] evt_set,
  input  logic [CODE_W-1:0] code_in,
  output logic [DATA_W-1:0] sticky_q,
  output logic [CODE_W-1:0] code_q
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      logic upd;
      logic nxt;
      always_comb begin
        upd = evt_set[i] | (clr_en & clr_mask[i]);
        nxt = evt_set[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sticky_q[i] <= 1'b0;
        else if (upd) sticky_q[i] <= nxt;
      end
    end else begin : g_plain
      assign sticky_q[i] = 1'b0;
    end
  end

  logic              code_upd;
  logic [CODE_W-1:0] code_nxt;
  always_comb begin
    code_upd = evt_set[WCRC_BIT] | (clr_en & clr_mask[WCRC_BIT]);
    code_nxt = evt_set[WCRC_BIT] ? code_in : '0;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= '0;
    else if (code_upd) code_q <= code_nxt;
  end

  logic bits_unused;
  assign bits_unused = ^((evt_set | clr_mask) & ~STICKY_MASK[DATA_W-1:0]);
endmodule

// File: rtl/cei_enable_reg.sv
module cei_enable_reg
  import card_evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] en_q
);
  logic [DATA_W-1:0] en_d;
  always_comb en_d = din & EN_MASK[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (load) en_q <= en_d;
  end

  logic din_unused;
  assign din_unused = ^(din & ~EN_MASK[DATA_W-1:0]);
endmodule

// File: rtl/cei_irq_map.sv
module cei_irq_map
  import card_evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stat_view,
  input  logic [DATA_W-1:0] en_q,
  input  logic              dat0_level,
  output logic              irq_q,
  output logic              wake_q
);
  logic [NIRQ-1:0]  irq_hit;
  logic [NWAKE-1:0] wake_hit;

  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    assign irq_hit[g] = en_q[IRQ_EN_IDX[g]] & stat_view[IRQ_ST_IDX[g]];
  end
  for (genvar g = 0; g < NWAKE; g++) begin : g_wake
    assign wake_hit[g] = en_q[WAKE_EN_IDX[g]] & stat_view[WAKE_ST_IDX[g]];
  end

  logic irq_d;
  logic wake_d;
  always_comb begin
    irq_d  = (|irq_hit) | (en_q[DAT0_EN] & dat0_level);
    wake_d = |wake_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      wake_q <= wake_d;
    end
  end

  logic view_unused;
  assign view_unused = ^{stat_view, en_q};
endmodule

// File: rtl/card_evt_irq_ctrl.sv
module card_evt_irq_ctrl
  import card_evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] evt_set,
  input  logic [CODE_W-1:0] wcrc_code,
  input  logic [3:0]        buf_flags,
  input  logic              bus_clk_on,
  input  logic              rd_ready,
  input  logic              wr_ready,
  input  logic              dat0_level,
  output logic              irq,
  output logic              wake,
  output logic [ERR_W-1:0]  err_flags,
  output logic              err_any
);
  logic [DATA_W-1:0] sticky_q;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] level_vec;
  logic [DATA_W-1:0] stat_view;
  logic              stat_clr;
  logic              en_load;

  always_comb begin
    stat_clr = reg_wr & ~reg_sel;
    en_load  = reg_wr & reg_sel;
  end

  cei_status_bank #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (stat_clr),
    .clr_mask (reg_wdata),
    .evt_set  (evt_set),
    .code_in  (wcrc_code),
    .sticky_q (sticky_q),
    .code_q   (code_q)
  );

  cei_enable_reg #(.DATA_W(DATA_W)) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (en_load),
    .din   (reg_wdata),
    .en_q  (en_q)
  );

  always_comb begin
    level_vec = '0;
    level_vec[BUF_LSB +: 4]             = buf_flags;
    level_vec[CLKON_BIT]                = bus_clk_on;
    level_vec[RDRDY_BIT]                = rd_ready;
    level_vec[WRRDY_BIT]                = wr_ready;
    level_vec[CODE_LSB +: CODE_W]       = code_q;
    stat_view = sticky_q | level_vec;
  end

  cei_irq_map #(.DATA_W(DATA_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_view  (stat_view),
    .en_q       (en_q),
    .dat0_level (dat0_level),
    .irq_q      (irq),
    .wake_q     (wake)
  );

  always_comb begin
    reg_rdata = reg_sel ? en_q : stat_view;
    err_flags = stat_view[ERR_W-1:0] & ERR_MASK;
    err_any   = |err_flags;
  end
endmodule

// File: rtl/card_evt_irq_ctrl_chk.sv
module card_evt_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [31:0] reg_wdata,
  input logic [31:0] evt_set,
  input logic [31:0] sticky_q,
  input logic [31:0] en_q,
  input logic        irq,
  input logic        wake
);
  // R1
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set[13] |=> sticky_q[13]);

  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[1] && !evt_set[1]) |=> !sticky_q[1]);

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set[0] && reg_wr && !reg_sel && reg_wdata[0]) |=> sticky_q[0]);

  // R6
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (en_q == ($past(reg_wdata) & 32'h0007_F01F)));

  // R7
  irq_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q[13] && en_q[2]) |=> irq);

  // R8
  wake_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q[30] && en_q[16]) |=> wake);
endmodule

bind card_evt_irq_ctrl card_evt_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .evt_set   (evt_set),
  .sticky_q  (sticky_q),
  .en_q      (en_q),
  .irq       (irq),
  .wake      (wake)
);

// File: tb/test_card_evt_irq_ctrl.sv
module test_card_evt_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_set = '0;
  logic [1:0]  wcrc_code = '0;
  logic [3:0]  buf_flags = '0;
  logic        bus_clk_on = 1'b0;
  logic        rd_ready = 1'b0;
  logic        wr_ready = 1'b0;
  logic        dat0_level = 1'b0;
  logic        irq;
  logic        wake;
  logic [5:0]  err_flags;
  logic        err_any;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  card_evt_irq_ctrl i_card_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .wcrc_code(wcrc_code), .buf_flags(buf_flags), .bus_clk_on(bus_clk_on),
    .rd_ready(rd_ready), .wr_ready(wr_ready), .dat0_level(dat0_level),
    .irq(irq), .wake(wake), .err_flags(err_flags), .err_any(err_any)
  );

  // ---------------- behavioural reference model ----------------
  localparam logic [31:0] M_STICKY = 32'hC300_782F;
  logic [31:0] m_st;
  logic [1:0]  m_code;
  logic [31:0] m_en;
  logic        m_irq, m_wake;

  function automatic logic [31:0] m_view();
    logic [31:0] v;
    v = m_st;
    v[29:26] = buf_flags;
    v[8] = bus_clk_on;
    v[7] = rd_ready;
    v[6] = wr_ready;
    v[10:9] = m_code;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_code = '0; m_en = '0; m_irq = 1'b0; m_wake = 1'b0;
    end else begin
      logic [31:0] v;
      v = m_view();
      m_irq = (m_en[0] && v[11]) || (m_en[1] && v[12]) || (m_en[2] && v[13]) ||
              (m_en[3] && v[6]) || (m_en[4] && v[7]) || (m_en[12] && dat0_level) ||
              (m_en[13] && v[14]) || (m_en[14] && v[30]) || (m_en[15] && v[31]);
      m_wake = (m_en[16] && v[30]) || (m_en[17] && v[31]) || (m_en[18] && v[14]);
      if (evt_set[2]) m_code = wcrc_code;
      else if (reg_wr && !reg_sel && reg_wdata[2]) m_code = 2'd0;
      for (int i = 0; i < 32; i++) begin
        if (M_STICKY[i]) begin
          if (evt_set[i]) m_st[i] = 1'b1;
          else if (reg_wr && !reg_sel && reg_wdata[i]) m_st[i] = 1'b0;
        end
      end
      if (reg_wr && reg_sel) m_en = reg_wdata & 32'h0007_F01F;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison, away from both edges
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      logic [31:0] v;
      v = m_view();
      check(reg_sel ? "R6 rdata enable" : "R1/R2/R4/R5 rdata status",
            reg_rdata, reg_sel ? m_en : v);
      check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
      check("R8 wake", {31'b0, wake}, {31'b0, m_wake});
      check("R9 err_flags", {26'b0, err_flags}, {26'b0, v[5:0] & 6'h2F});
      check("R9 err_any", {31'b0, err_any}, {31'b0, |(v[5:0] & 6'h2F)});
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic idle();
    reg_wr = 1'b0; evt_set = '0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc(); idle();
  endtask

  task automatic pulse(input logic [31:0] e, input logic [1:0] code);
    evt_set = e; wcrc_code = code;
    cyc(); idle();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10 reset values while held
    reg_sel = 1'b0; #1; check("R10 status in reset", reg_rdata, 32'h0);
    reg_sel = 1'b1; #1; check("R10 enable in reset", reg_rdata, 32'h0);
    check("R10 irq in reset", {31'b0, irq}, 32'h0);
    check("R10 wake in reset", {31'b0, wake}, 32'h0);
    reg_sel = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;

    // R1 latch card insertion; R4 pulse at level position 28 ignored
    pulse(32'h9000_0000, 2'd0);
    cyc();
    check("R1 bit31 latched", {31'b0, reg_rdata[31]}, 32'h1);
    check("R4 pulse at level pos ignored", {31'b0, reg_rdata[28]}, 32'h0);
    buf_flags = 4'b0100; rd_ready = 1'b1; #1;
    check("R4 level mirrors input", reg_rdata & 32'h3C00_01C0, 32'h1000_0080);
    wr(1'b0, 32'hFFFF_FFFF);
    check("R4 level unaffected by write", reg_rdata & 32'h3C00_01C0, 32'h1000_0080);
    buf_flags = '0; rd_ready = 1'b0;

    // R2 write of zero keeps, write of one clears
    pulse(32'h8000_0000, 2'd0);
    wr(1'b0, 32'h0000_0000);
    check("R2 zero write keeps", {31'b0, reg_rdata[31]}, 32'h1);
    wr(1'b0, 32'h8000_0000);
    check("R2 one write clears", {31'b0, reg_rdata[31]}, 32'h0);

    // R3 pulse and clear on same bit
    evt_set = 32'h1; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h1;
    cyc(); idle();
    check("R3 set wins", {31'b0, reg_rdata[0]}, 32'h1);

    // R5 CRC response code capture
    pulse(32'h4, 2'd2);
    check("R5 code no-response", {30'b0, reg_rdata[10:9]}, 32'h2);
    wr(1'b0, 32'h0000_0600);
    check("R5 code write ignored", {30'b0, reg_rdata[10:9]}, 32'h2);
    wr(1'b0, 32'h0000_0004);
    check("R5 code cleared with bit 2", {30'b0, reg_rdata[10:9]}, 32'h0);

    // R9 error view: bit 0 still set, bit 4 not sticky
    pulse(32'h30, 2'd0);
    check("R9 err_flags", {26'b0, err_flags}, 32'h21);
    check("R9 err_any", {31'b0, err_any}, 32'h1);

    // R6 enable load masking
    wr(1'b1, 32'hFFFF_FFFF);
    reg_sel = 1'b1; #1;
    check("R6 enable implemented bits", reg_rdata, 32'h0007_F01F);
    wr(1'b1, 32'h0000_0004);
    reg_sel = 1'b0;
    wr(1'b0, 32'hFFFF_FFFF);
    cyc();

    // R7 irq one clock after status
    pulse(32'h0000_2000, 2'd0);
    check("R7 irq not yet", {31'b0, irq}, 32'h0);
    cyc();
    check("R7 irq from cmd end", {31'b0, irq}, 32'h1);
    wr(1'b0, 32'h0000_2000);
    cyc();
    check("R7 irq drops", {31'b0, irq}, 32'h0);
    wr(1'b1, 32'h0000_1000);
    dat0_level = 1'b1;
    cyc();
    check("R7 irq from dat0", {31'b0, irq}, 32'h1);
    dat0_level = 1'b0;

    // R8 wake from removal
    wr(1'b1, 32'h0001_0000);
    pulse(32'h4000_0000, 2'd0);
    check("R8 wake not yet", {31'b0, wake}, 32'h0);
    cyc();
    check("R8 wake from removal", {31'b0, wake}, 32'h1);
    check("R7 enable 14 off keeps irq low", {31'b0, irq}, 32'h0);

    // random traffic compared against the model every clock
    for (int n = 0; n < 4000; n++) begin
      evt_set    = $urandom & $urandom & $urandom;
      wcrc_code  = 2'($urandom);
      reg_wr     = ($urandom % 4) == 0;
      reg_sel    = 1'($urandom);
      reg_wdata  = $urandom;
      buf_flags  = 4'($urandom);
      bus_clk_on = 1'($urandom);
      rd_ready   = 1'($urandom);
      wr_ready   = 1'($urandom);
      dat0_level = 1'($urandom);
      cyc();
    end
    idle();

    // R10 asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    reg_sel = 1'b0; buf_flags = '0; bus_clk_on = 1'b0; rd_ready = 1'b0; wr_ready = 1'b0; #1;
    check("R10 status cleared", reg_rdata, 32'h0);
    reg_sel = 1'b1; #1;
    check("R10 enable cleared", reg_rdata, 32'h0);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule